// File: doc/BRIEF.md
# Paced LCD Init Command Serializer

This block brings a serial LCD out of its power-on state by sending a short, fixed list of commands. Each command leaves as a 9-bit frame: a leading data/command flag (0 for a command) followed by the 8-bit code, most significant bit first. A single start pulse runs the whole list. The block raises a done flag when the last frame and its trailing gap are complete.

Each bit is held on the data line for a long interval, timed by a pacing counter, so that the transfer can be watched on a board pin with slow equipment. Inside every bit interval the serial clock is low first and then high, so the data is already stable when the clock rises. Chip select frames each command and returns high for at least one full interval between commands. The hold length is a parameter: hardware uses the full count, and a bench can shorten it.

Top module: `lcd_init_serializer`

## Requirements
- R1: While `rst` is high, `cs_n` is 1, `sclk` is 0, `done` is 0 and `lcd_rst_n` is 0. From the first clock after reset is released, `lcd_rst_n` is 1.
- R2: Every frame holds exactly 9 bits, sampled on the rising edges of `sclk`. The first bit is the flag (0 = command) and the next eight are the command code, most significant bit first.
- R3: A sequence sends code 0x11 first and code 0x03 second. The second frame begins only after the first frame's chip-select window has closed.
- R4: `sclk` rises only while `cs_n` is low, and each low window of `cs_n` contains exactly 9 rising edges of `sclk`.
- R5: `sdo` does not change while `sclk` is high.
- R6: Within a frame, consecutive rising edges of `sclk` are exactly HOLD_CYCLES+3 clock cycles apart. The pacing counter's done pulse lasts one cycle and never appears while pacing is off.
- R7: Between two frames, `cs_n` stays high for at least HOLD_CYCLES+1 clock cycles.
- R8: `done` rises after the last frame, with `cs_n` high. While `done` is high, `cs_n` stays 1 and `sclk` stays 0.
- R9: A `start` pulse that arrives while a sequence is running has no effect. The sequence still sends exactly two frames.
- R10: A `start` pulse while `done` is high clears `done` within two cycles and runs the full sequence again.
- R11: `start` asserted while `rst` is high is ignored. No frame follows the release of reset until a new `start` arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run the command list |
| cs_n | output | 1 | Chip select to the LCD, active low |
| sclk | output | 1 | Slow serial clock, data sampled on its rising edge |
| sdo | output | 1 | Serial data to the LCD |
| lcd_rst_n | output | 1 | LCD reset, low during system reset |
| done | output | 1 | High after the full list has been sent |

## Verification
Two event pairs can land in the same cycle. A request can coincide with reset, and a request can arrive while the sequencer is busy. The bench holds `start` high across the reset cycles and then confirms that `cs_n` stays high with no frame seen. It also fires a second `start` partway through the first frame and confirms that exactly two frames with the expected codes still appear. A monitor rebuilds each frame from `sdo` at every rise of `sclk` and measures the spacing of the rises and the chip-select gaps against the hold parameter.

// File: rtl/lcd_ser_pkg.sv
package lcd_ser_pkg;

    localparam int unsigned FRAME_W = 9;
    localparam int unsigned CODE_W  = 8;
    localparam logic        DC_CMD  = 1'b0;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_LOAD     = 3'd1,
        ST_SHIFT    = 3'd2,
        ST_WAIT     = 3'd3,
        ST_NEXT_CMD = 3'd4,
        ST_DONE     = 3'd5
    } ser_state_e;

    // Power-up command list, in send order.
    function automatic logic [CODE_W-1:0] init_cmd(input int unsigned i);
        case (i)
            0:       return 8'h11;  // leave sleep
            1:       return 8'h03;  // booster on
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/lcd_bit_timer.sv
module lcd_bit_timer #(
    parameter int unsigned HOLD_CYCLES = 8388608
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick,
    output logic half
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam int unsigned HALF  = HOLD_CYCLES / 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run) begin
            r_d.cnt  = '0;
            r_d.tick = 1'b0;
        end else if (r_q.cnt == CNT_W'(HOLD_CYCLES)) begin
            r_d.cnt  = '0;
            r_d.tick = 1'b1;
        end else begin
            r_d.cnt  = r_q.cnt + 1'b1;
            r_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tick = r_q.tick;
    assign half = (r_q.cnt >= CNT_W'(HALF));

endmodule

// File: rtl/lcd_cmd_table.sv
module lcd_cmd_table
    import lcd_ser_pkg::*;
#(
    parameter int unsigned NUM_CMDS = 2,
    parameter int unsigned IDX_W    = 1
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [CODE_W-1:0] code,
    output logic              last
);
    always_comb begin
        code = init_cmd(int'(idx));
        last = (idx == IDX_W'(NUM_CMDS - 1));
    end
endmodule

// File: rtl/lcd_init_serializer.sv
module lcd_init_serializer
    import lcd_ser_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 8388608,
    parameter int unsigned NUM_CMDS    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic cs_n,
    output logic sclk,
    output logic sdo,
    output logic lcd_rst_n,
    output logic done
);
    localparam int unsigned IDX_W  = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1;
    localparam int unsigned BCNT_W = $clog2(FRAME_W + 1);

    typedef struct packed {
        ser_state_e          st;
        logic [FRAME_W-1:0]  frame;
        logic [BCNT_W-1:0]   bits;
        logic [IDX_W-1:0]    idx;
        logic                cs_n;
        logic                sclk;
        logic                sdo;
        logic                done;
        logic                rst_n;
    } ctl_t;

    ctl_t r_d, r_q;

    logic              pace_run;
    logic              pace_tick;
    logic              pace_half;
    logic [CODE_W-1:0] cmd_code;
    logic              cmd_last;

    lcd_bit_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .run (pace_run),
        .tick(pace_tick),
        .half(pace_half)
    );

    lcd_cmd_table #(
        .NUM_CMDS(NUM_CMDS),
        .IDX_W   (IDX_W)
    ) u_table (
        .idx (r_q.idx),
        .code(cmd_code),
        .last(cmd_last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rst_n = 1'b1;
        pace_run  = 1'b0;
        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                r_d.cs_n = 1'b1;
                r_d.sclk = 1'b0;
                if (start) begin
                    r_d.st   = ST_LOAD;
                    r_d.done = 1'b0;
                    r_d.idx  = '0;
                end
            end
            ST_LOAD: begin
                r_d.frame = {DC_CMD, cmd_code};
                r_d.bits  = '0;
                r_d.cs_n  = 1'b0;
                r_d.st    = ST_SHIFT;
            end
            ST_SHIFT: begin
                r_d.sdo   = r_q.frame[FRAME_W-1];
                r_d.frame = {r_q.frame[FRAME_W-2:0], 1'b0};
                r_d.bits  = r_q.bits + 1'b1;
                r_d.sclk  = 1'b0;
                r_d.st    = ST_WAIT;
            end
            ST_WAIT: begin
                pace_run = 1'b1;
                r_d.sclk = pace_half && !pace_tick;
                if (pace_tick) begin
                    if (r_q.bits == BCNT_W'(FRAME_W)) begin
                        r_d.cs_n = 1'b1;
                        r_d.sdo  = 1'b0;
                        r_d.st   = ST_NEXT_CMD;
                    end else begin
                        r_d.st = ST_SHIFT;
                    end
                end
            end
            ST_NEXT_CMD: begin
                pace_run = 1'b1;
                r_d.cs_n = 1'b1;
                r_d.sclk = 1'b0;
                if (pace_tick) begin
                    if (cmd_last) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_DONE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_LOAD;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n      = r_q.cs_n;
    assign sclk      = r_q.sclk;
    assign sdo       = r_q.sdo;
    assign done      = r_q.done;
    assign lcd_rst_n = r_q.rst_n;

endmodule

// File: rtl/lcd_init_serializer_chk.sv
module lcd_init_serializer_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic sdo,
    input logic done,
    input logic lcd_rst_n,
    input logic pace_run,
    input logic pace_tick
);
    assert_reset_outputs_R1: assert property (@(posedge clk)
        rst |=> (cs_n && !sclk && !done && !lcd_rst_n));

    assert_sclk_inside_frame_R4: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    assert_sdo_steady_high_R5: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sdo));

    assert_tick_single_R6: assert property (@(posedge clk) disable iff (rst)
        pace_tick |=> !pace_tick);

    assert_tick_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
        !pace_run |=> !pace_tick);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !sclk));
endmodule

bind lcd_init_serializer lcd_init_serializer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .sdo      (sdo),
    .done     (done),
    .lcd_rst_n(lcd_rst_n),
    .pace_run (pace_run),
    .pace_tick(pace_tick)
);

// File: tb/lcd_init_serializer_test.sv
`timescale 1ns/1ps
module lcd_init_serializer_test;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic cs_n, sclk, sdo, lcd_rst_n, done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lcd_init_serializer #(.HOLD_CYCLES(HOLD), .NUM_CMDS(2)) uut (
        .clk(clk), .rst(rst), .start(start), .cs_n(cs_n), .sclk(sclk),
        .sdo(sdo), .lcd_rst_n(lcd_rst_n), .done(done)
    );

    // Port monitor, sampled on the falling clock edge.
    logic       mon_clr = 1'b0;
    int         cyc = 0, frames = 0, outside = 0, glitch = 0;
    int         minp = 1000000, maxp = 0, gapmin = 1000000;
    int         last_rise = 0, cs_rise = 0, curbits = 0;
    bit         have_rise = 1'b0;
    logic [8:0] cur = '0;
    logic [8:0] rx [0:3];
    int         nb [0:3];
    logic       p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            frames = 0; outside = 0; glitch = 0;
            minp = 1000000; maxp = 0; gapmin = 1000000;
        end else begin
            if (p_cs && !cs_n) begin
                cur = '0; curbits = 0; have_rise = 1'b0;
                if (frames > 0 && (cyc - cs_rise) < gapmin) gapmin = cyc - cs_rise;
            end
            if (!p_sclk && sclk) begin
                if (cs_n) outside++;
                cur = {cur[7:0], sdo};
                curbits++;
                if (have_rise) begin
                    if (cyc - last_rise < minp) minp = cyc - last_rise;
                    if (cyc - last_rise > maxp) maxp = cyc - last_rise;
                end
                have_rise = 1'b1;
                last_rise = cyc;
            end
            if (p_sclk && sclk && (sdo !== p_sdo)) glitch++;
            if (!p_cs && cs_n) begin
                if (frames < 4) begin
                    rx[frames] = cur;
                    nb[frames] = curbits;
                end
                frames++;
                cs_rise = cyc;
            end
        end
        p_cs = cs_n; p_sclk = sclk; p_sdo = sdo;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset values at the ports
        check(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
        check(sclk == 1'b0 && done == 1'b0, "R1", "sclk|done in reset", {sclk, done}, 0);
        check(lcd_rst_n == 1'b0, "R1", "lcd_rst_n in reset", lcd_rst_n, 0);
        rst = 1'b0; start = 1'b0;
        repeat (40) @(negedge clk);
        check(lcd_rst_n == 1'b1, "R1", "lcd_rst_n after reset", lcd_rst_n, 1);
        // R11: start held during reset is dropped
        check(frames == 0, "R11", "frames after reset with start", frames, 0);
        check(cs_n == 1'b1, "R11", "cs_n idle after reset", cs_n, 1);
    endtask

    task automatic check_sequence(input string tag);
        check(done == 1'b1, "R8", {tag, " done high"}, done, 1);
        check(cs_n == 1'b1 && sclk == 1'b0, "R8", {tag, " quiet while done"}, {cs_n, sclk}, 2);
        check(frames == 2, tag, "frame count", frames, 2);
        check(nb[0] == 9 && nb[1] == 9, "R4", "bits per frame", nb[0] * 100 + nb[1], 909);
        check(rx[0] == 9'h011, "R2", "first frame flag+code", rx[0], 9'h011);
        check(rx[1] == 9'h003, "R3", "second frame flag+code", rx[1], 9'h003);
        check(outside == 0, "R4", "sclk rises outside cs", outside, 0);
        check(glitch == 0, "R5", "sdo moves while sclk high", glitch, 0);
        check(minp == HOLD + 3 && maxp == HOLD + 3, "R6", "bit spacing", minp * 1000 + maxp,
              (HOLD + 3) * 1001);
        check(gapmin >= HOLD + 1, "R7", "cs high gap", gapmin, HOLD + 1);
    endtask

    task automatic t_first_run();
        clear_mon();
        pulse_start();
        wait_done();
        check_sequence("R3");
    endtask

    task automatic t_restart_from_done();
        clear_mon();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R10", "done cleared by start", done, 0);
        wait_done();
        check_sequence("R10");
    endtask

    task automatic t_start_while_busy();
        clear_mon();
        pulse_start();
        repeat (40) @(negedge clk);
        check(cs_n == 1'b0, "R9", "frame in progress", cs_n, 0);
        pulse_start();
        wait_done();
        check_sequence("R9");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_run();
        t_restart_from_done();
        t_start_while_busy();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule